// File: doc/BRIEF.md
# Symmetric Pre-Add Decimating FIR Cell

This block is an eight-tap FIR cell for 10-bit signed samples. It relies on coefficient symmetry: the taps form four pairs, and the two samples of each pair are added before they reach a multiplier. Eight taps therefore need only four multiplies per cycle. Samples move through a forward delay path. The sample that leaves the end of that path is written into one of two LIFO buffers. The other LIFO is read back into a reverse delay path, so the samples come out in reverse time order. A transfer strobe swaps the two LIFOs. This keeps the pairing of forward and reverse samples correct when the cell decimates.

Every delay stage between taps lasts a run-time number of shifts, from 1 to 16. The forward and reverse operands of the pre-adder can each be forced to zero, which gives asymmetric or one-sided filtering. The summed products collect in a wide signed accumulator. When accumulation is released, the accumulator drains into an output holding register and a new sum starts. Coefficients arrive each cycle on a port that an external coefficient store drives.

Top module: `symfir_cell`

## Requirements
- R1: While reset is high, and right after it, `holdOut` reads 0. Reset clears the internal state (delay lines, both LIFOs, accumulator, holding register), so a run of idle cycles after reset leaves `holdOut` at 0.
- R2: For pair k (k = 0..3), the product is (forward tap k + reverse tap k) × coefficient k. The four products are summed. Coefficient k is `coefIn[10k+9:10k]`, two's complement.
- R3: `shiftEn_n` is active low. When it is high, the forward path, the reverse path and both LIFOs keep their contents.
- R4: `fwdEn_n` is active low. When it is high, the forward operand of every pre-add is zero.
- R5: `revEn_n` is active low. When it is high, the reverse operand of every pre-add is zero.
- R6: `decimM1` holds D−1, with D from 1 to 16. After a shift, forward tap k holds the sample shifted in k·D shifts ago (tap 0 is the newest). Reverse tap 3−k holds the value popped k·D shifts ago.
- R7: On each shift, the sample the forward path held k = 4·D shifts back (read before the shift) is pushed into the write-side LIFO. The push is dropped if that LIFO already holds 64 entries. On the same shift, the read-side LIFO pops its top into the reverse path; if the read side is empty, a zero enters instead.
- R8: `xfer_n` is active low. It swaps the two LIFOs: the write side becomes the read side with its contents intact, and the old read side becomes an empty write side. When a shift happens in the same cycle, the shift uses the sides as they were before the swap.
- R9: When `accEn` is high, the product sum is added to the accumulator. When it is low, `holdOut` takes the accumulator value and the accumulator restarts from the current product sum.
- R10: All data and control inputs are registered on the rising clock edge. The effect of the inputs sampled at edge n appears on `holdOut` after edge n+3.
- R11: The accumulator is 28 bits, signed, and wraps modulo 2^28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 10 | Input sample, two's complement |
| coefIn | input | 40 | Four 10-bit signed coefficients, pair k at bits 10k+9:10k |
| shiftEn_n | input | 1 | Shift enable, active low |
| fwdEn_n | input | 1 | Forward operand enable, active low |
| revEn_n | input | 1 | Reverse operand enable, active low |
| xfer_n | input | 1 | LIFO swap, active low |
| accEn | input | 1 | Accumulate when high, drain to holding register when low |
| decimM1 | input | 4 | Decimation factor minus one |
| holdOut | output | 28 | Output holding register, signed |

## Verification
The bench builds the cell with its default parameters: four tap pairs, a maximum decimation of 16, LIFOs of 64 entries and a 28-bit accumulator. It runs decimation factors 1, 2, 3 and 16. At factor 16 the LIFOs are swapped only after 100 shifts, so the write side fills and later pushes are dropped. A directed run of 200 accumulations of the largest product drives the accumulator past its signed range and into a wrap.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

  // Per-cycle strobes from control to datapath, already aligned to the
  // pipeline stage that consumes each one.
  typedef struct packed {
    logic shiftNow;   // advance delay lines and LIFOs this edge
    logic xferNow;    // swap LIFO roles this edge
    logic fwdOn;      // forward operand enabled at the pre-add stage
    logic revOn;      // reverse operand enabled at the pre-add stage
    logic accOn;      // accumulate (1) or drain (0) at the MAC stage
  } firStrobes_t;

endpackage

// File: rtl/symfir_ctrl.sv
module symfir_ctrl #(
  parameter int DEC_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     shiftEn_n,
  input  logic                     fwdEn_n,
  input  logic                     revEn_n,
  input  logic                     xfer_n,
  input  logic                     accEn,
  input  logic [DEC_W-1:0]         decimM1,
  output symfir_pkg::firStrobes_t  strobes,
  output logic [DEC_W-1:0]         decimSel
);

  // Stage 1: input registers (active-low pins turned to active-high)
  logic s1Shift, s1Xfer, s1Fwd, s1Rev, s1Acc;
  // Stage 2: operand enables travel with the tap values
  logic s2Fwd, s2Rev, s2Acc;
  // Stage 3: accumulate control travels with the pre-add sums
  logic s3Acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Shift  <= 1'b0;
      s1Xfer   <= 1'b0;
      s1Fwd    <= 1'b0;
      s1Rev    <= 1'b0;
      s1Acc    <= 1'b1;
      s2Fwd    <= 1'b0;
      s2Rev    <= 1'b0;
      s2Acc    <= 1'b1;
      s3Acc    <= 1'b1;
      decimSel <= '0;
    end else begin
      s1Shift  <= ~shiftEn_n;
      s1Xfer   <= ~xfer_n;
      s1Fwd    <= ~fwdEn_n;
      s1Rev    <= ~revEn_n;
      s1Acc    <= accEn;
      s2Fwd    <= s1Fwd;
      s2Rev    <= s1Rev;
      s2Acc    <= s1Acc;
      s3Acc    <= s2Acc;
      decimSel <= decimM1;
    end
  end

  assign strobes.shiftNow = s1Shift;
  assign strobes.xferNow  = s1Xfer;
  assign strobes.fwdOn    = s2Fwd;
  assign strobes.revOn    = s2Rev;
  assign strobes.accOn    = s3Acc;

  // R10: a drain at the MAC stage comes from a low accEn two edges earlier
  a_r10_acc_follows_pin: assert property (@(posedge clk) disable iff (rst)
    (!s1Acc) |=> ##1 (!s3Acc));

endmodule

// File: rtl/symfir_lifo_pair.sv
module symfir_lifo_pair #(
  parameter int DATA_W = 10,
  parameter int DEPTH  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shiftNow,
  input  logic              xferNow,
  input  logic [DATA_W-1:0] pushData,
  output logic [DATA_W-1:0] popData
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [2][DEPTH];
  logic [CNT_W-1:0]  cnt [2];
  logic              wrSel;
  logic              rdSel;
  logic              doPush, doPop;
  logic [CNT_W-1:0]  topIdx;
  logic [CNT_W-1:0]  nextWrCnt, nextRdCnt;

  assign rdSel  = ~wrSel;
  assign doPush = shiftNow && (cnt[wrSel] < CNT_W'(DEPTH));
  assign doPop  = shiftNow && (cnt[rdSel] != '0);
  assign topIdx = cnt[rdSel] - CNT_W'(1);
  assign popData = (cnt[rdSel] != '0) ? mem[rdSel][topIdx[PTR_W-1:0]] : '0;

  assign nextWrCnt = cnt[wrSel] + CNT_W'(doPush);
  assign nextRdCnt = cnt[rdSel] - CNT_W'(doPop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wrSel  <= 1'b0;
      cnt[0] <= '0;
      cnt[1] <= '0;
      for (int s = 0; s < 2; s++)
        for (int j = 0; j < DEPTH; j++)
          mem[s][j] <= '0;
    end else begin
      if (doPush) mem[wrSel][cnt[wrSel][PTR_W-1:0]] <= pushData;
      cnt[wrSel] <= nextWrCnt;
      if (xferNow) begin
        // old read side becomes an empty write side
        cnt[rdSel] <= '0;
        wrSel      <= rdSel;
      end else begin
        cnt[rdSel] <= nextRdCnt;
      end
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
    (cnt[0] <= CNT_W'(DEPTH)) && (cnt[1] <= CNT_W'(DEPTH)));

  // R7: a full write side stays full across a shift without swap
  a_r7_full_drops: assert property (@(posedge clk) disable iff (rst)
    (shiftNow && !xferNow && cnt[wrSel] == CNT_W'(DEPTH))
      |=> (cnt[wrSel] == CNT_W'(DEPTH)));

  // R8: a transfer flips the roles
  a_r8_roles_swap: assert property (@(posedge clk) disable iff (rst)
    xferNow |=> (wrSel != $past(wrSel)));

  // R8: the new write side starts empty
  a_r8_new_write_empty: assert property (@(posedge clk) disable iff (rst)
    xferNow |=> (cnt[wrSel] == '0));

endmodule

// File: rtl/symfir_datapath.sv
module symfir_datapath #(
  parameter int DATA_W    = 10,
  parameter int COEF_W    = 10,
  parameter int PAIRS     = 4,
  parameter int MAX_DECIM = 16,
  parameter int ACC_W     = 28
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic signed [DATA_W-1:0]           sampleIn,
  input  logic        [PAIRS*COEF_W-1:0]     coefIn,
  input  logic        [$clog2(MAX_DECIM)-1:0] decimSel,
  input  symfir_pkg::firStrobes_t            strobes,
  output logic signed [ACC_W-1:0]            holdOut
);

  localparam int SUM_W      = DATA_W + 1;
  localparam int PROD_W     = SUM_W + COEF_W;
  localparam int LIFO_DEPTH = PAIRS * MAX_DECIM;

  // ---------------- input registers ----------------
  logic signed [DATA_W-1:0] s1Sample;
  logic signed [COEF_W-1:0] s1Coef [PAIRS];
  logic signed [COEF_W-1:0] s2Coef [PAIRS];
  logic signed [COEF_W-1:0] s3Coef [PAIRS];

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Sample <= '0;
      for (int k = 0; k < PAIRS; k++) begin
        s1Coef[k] <= '0;
        s2Coef[k] <= '0;
        s3Coef[k] <= '0;
      end
    end else begin
      s1Sample <= sampleIn;
      for (int k = 0; k < PAIRS; k++) begin
        s1Coef[k] <= coefIn[k*COEF_W +: COEF_W];
        s2Coef[k] <= s1Coef[k];
        s3Coef[k] <= s2Coef[k];
      end
    end
  end

  // ---------------- forward decimation path ----------------
  logic signed [DATA_W-1:0] fHead;
  logic signed [DATA_W-1:0] fOut [PAIRS];   // last one is the path tail
  logic signed [DATA_W-1:0] fTap [PAIRS];

  always_ff @(posedge clk) begin
    if (rst)                   fHead <= '0;
    else if (strobes.shiftNow) fHead <= s1Sample;
  end

  for (genvar c = 0; c < PAIRS; c++) begin : g_fwd
    logic signed [DATA_W-1:0] line [MAX_DECIM];
    logic signed [DATA_W-1:0] lineIn;
    if (c == 0) begin : g_from_head
      assign lineIn = fHead;
    end else begin : g_from_prev
      assign lineIn = fOut[c-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < MAX_DECIM; j++) line[j] <= '0;
      end else if (strobes.shiftNow) begin
        line[0] <= lineIn;
        for (int j = 1; j < MAX_DECIM; j++) line[j] <= line[j-1];
      end
    end
    assign fOut[c] = line[decimSel];
  end

  assign fTap[0] = fHead;
  for (genvar k = 1; k < PAIRS; k++) begin : g_ftap
    assign fTap[k] = fOut[k-1];
  end

  // ---------------- LIFO pair ----------------
  logic [DATA_W-1:0] popData;

  symfir_lifo_pair #(.DATA_W(DATA_W), .DEPTH(LIFO_DEPTH)) u_lifo (
    .clk      (clk),
    .rst      (rst),
    .shiftNow (strobes.shiftNow),
    .xferNow  (strobes.xferNow),
    .pushData (fOut[PAIRS-1]),
    .popData  (popData)
  );

  // ---------------- reverse decimation path ----------------
  logic signed [DATA_W-1:0] rHead;
  logic signed [DATA_W-1:0] rOut [PAIRS-1];
  logic signed [DATA_W-1:0] rTap [PAIRS];

  always_ff @(posedge clk) begin
    if (rst)                   rHead <= '0;
    else if (strobes.shiftNow) rHead <= popData;
  end

  for (genvar c = 0; c < PAIRS-1; c++) begin : g_rev
    logic signed [DATA_W-1:0] line [MAX_DECIM];
    logic signed [DATA_W-1:0] lineIn;
    if (c == 0) begin : g_from_head
      assign lineIn = rHead;
    end else begin : g_from_prev
      assign lineIn = rOut[c-1];
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        for (int j = 0; j < MAX_DECIM; j++) line[j] <= '0;
      end else if (strobes.shiftNow) begin
        line[0] <= lineIn;
        for (int j = 1; j < MAX_DECIM; j++) line[j] <= line[j-1];
      end
    end
    assign rOut[c] = line[decimSel];
  end

  assign rTap[PAIRS-1] = rHead;
  for (genvar c = 0; c < PAIRS-1; c++) begin : g_rtap
    assign rTap[PAIRS-2-c] = rOut[c];
  end

  // ---------------- pre-add ALU ----------------
  logic signed [SUM_W-1:0] preSum [PAIRS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < PAIRS; k++) preSum[k] <= '0;
    end else begin
      for (int k = 0; k < PAIRS; k++)
        preSum[k] <= (strobes.fwdOn ? {fTap[k][DATA_W-1], fTap[k]} : '0)
                   + (strobes.revOn ? {rTap[k][DATA_W-1], rTap[k]} : '0);
    end
  end

  // ---------------- multiply-accumulate ----------------
  logic signed [PROD_W-1:0] prod [PAIRS];
  logic signed [ACC_W-1:0]  prodSum;
  logic signed [ACC_W-1:0]  accQ, holdQ;

  for (genvar k = 0; k < PAIRS; k++) begin : g_mul
    assign prod[k] = preSum[k] * s3Coef[k];
  end

  always_comb begin
    prodSum = '0;
    for (int k = 0; k < PAIRS; k++) prodSum = prodSum + ACC_W'(prod[k]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      holdQ <= '0;
    end else if (strobes.accOn) begin
      accQ  <= accQ + prodSum;
    end else begin
      holdQ <= accQ;
      accQ  <= prodSum;
    end
  end

  assign holdOut = holdQ;

  // R1: first cycle out of reset sees cleared accumulator and holding register
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (holdQ == '0 && accQ == '0));

  // R3: no shift, no movement in either path head
  a_r3_paths_hold: assert property (@(posedge clk) disable iff (rst)
    !strobes.shiftNow |=> ($stable(fHead) && $stable(rHead)));

  // R9: holding register only moves on a drain
  a_r9_hold_steady: assert property (@(posedge clk) disable iff (rst)
    strobes.accOn |=> $stable(holdQ));

  // R9: a drain copies the accumulator
  a_r9_drain_copies: assert property (@(posedge clk) disable iff (rst)
    !strobes.accOn |=> (holdQ == $past(accQ)));

endmodule

// File: rtl/symfir_cell.sv
module symfir_cell #(
  parameter int DATA_W    = 10,
  parameter int COEF_W    = 10,
  parameter int PAIRS     = 4,
  parameter int MAX_DECIM = 16,
  parameter int ACC_W     = 28
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic signed [DATA_W-1:0]            sampleIn,
  input  logic        [PAIRS*COEF_W-1:0]      coefIn,
  input  logic                                shiftEn_n,
  input  logic                                fwdEn_n,
  input  logic                                revEn_n,
  input  logic                                xfer_n,
  input  logic                                accEn,
  input  logic        [$clog2(MAX_DECIM)-1:0] decimM1,
  output logic signed [ACC_W-1:0]             holdOut
);

  localparam int DEC_W = $clog2(MAX_DECIM);

  symfir_pkg::firStrobes_t strobes;
  logic [DEC_W-1:0]        decimSel;

  symfir_ctrl #(.DEC_W(DEC_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .shiftEn_n (shiftEn_n),
    .fwdEn_n   (fwdEn_n),
    .revEn_n   (revEn_n),
    .xfer_n    (xfer_n),
    .accEn     (accEn),
    .decimM1   (decimM1),
    .strobes   (strobes),
    .decimSel  (decimSel)
  );

  symfir_datapath #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .PAIRS(PAIRS),
    .MAX_DECIM(MAX_DECIM), .ACC_W(ACC_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sampleIn (sampleIn),
    .coefIn   (coefIn),
    .decimSel (decimSel),
    .strobes  (strobes),
    .holdOut  (holdOut)
  );

endmodule

// File: tb/sim_symfir_cell.sv
module sim_symfir_cell;

  localparam int DATA_W = 10;
  localparam int COEF_W = 10;
  localparam int PAIRS  = 4;
  localparam int MAXD   = 16;
  localparam int ACC_W  = 28;
  localparam int DEPTH  = PAIRS * MAXD;
  localparam int HIST   = PAIRS * MAXD + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [DATA_W-1:0]     sampleIn = '0;
  logic [PAIRS*COEF_W-1:0]      coefIn = '0;
  logic shiftEn_n = 1'b1, fwdEn_n = 1'b1, revEn_n = 1'b1, xfer_n = 1'b1, accEn = 1'b1;
  logic [3:0]                   decimM1 = '0;
  logic signed [ACC_W-1:0]      holdOut;

  symfir_cell u0 (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .coefIn(coefIn),
    .shiftEn_n(shiftEn_n), .fwdEn_n(fwdEn_n), .revEn_n(revEn_n),
    .xfer_n(xfer_n), .accEn(accEn), .decimM1(decimM1), .holdOut(holdOut)
  );

  always #2 clk = ~clk;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // ---------------- reference model state ----------------
  logic signed [DATA_W-1:0] fh [HIST];
  logic signed [DATA_W-1:0] rh [HIST];
  logic signed [DATA_W-1:0] lf [2][DEPTH];
  int lc [2];
  int ws;
  int dec;
  logic signed [ACC_W-1:0] mAcc, mHold;
  logic signed [ACC_W-1:0] expHold [8192];
  int stepIdx;

  task automatic check(input string req, input logic signed [ACC_W-1:0] act,
                       input logic signed [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: holdOut=%0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [PAIRS*COEF_W-1:0] packC(input int a, input int b,
                                                    input int c, input int d);
    return {COEF_W'(d), COEF_W'(c), COEF_W'(b), COEF_W'(a)};
  endfunction

  task automatic modelClear(input int d);
    for (int i = 0; i < HIST; i++) begin fh[i] = '0; rh[i] = '0; end
    for (int s = 0; s < 2; s++) begin
      lc[s] = 0;
      for (int j = 0; j < DEPTH; j++) lf[s][j] = '0;
    end
    ws = 0; dec = d; mAcc = '0; mHold = '0; stepIdx = 0;
  endtask

  task automatic modelStep(input logic signed [DATA_W-1:0] x,
                           input logic [PAIRS*COEF_W-1:0] c,
                           input bit sh, input bit fw, input bit rv,
                           input bit xf, input bit ac);
    logic signed [DATA_W-1:0] tailOld, popV;
    int rd, fv, rvv;
    longint p;
    if (sh) begin
      tailOld = fh[PAIRS*dec];
      for (int i = HIST-1; i > 0; i--) fh[i] = fh[i-1];
      fh[0] = x;
      if (lc[ws] < DEPTH) begin lf[ws][lc[ws]] = tailOld; lc[ws]++; end
      rd = 1 - ws;
      if (lc[rd] > 0) begin lc[rd]--; popV = lf[rd][lc[rd]]; end
      else popV = '0;
      for (int i = HIST-1; i > 0; i--) rh[i] = rh[i-1];
      rh[0] = popV;
    end
    if (xf) begin ws = 1 - ws; lc[ws] = 0; end
    p = 0;
    for (int k = 0; k < PAIRS; k++) begin
      fv  = fw ? int'(fh[k*dec]) : 0;
      rvv = rv ? int'(rh[(PAIRS-1-k)*dec]) : 0;
      p += longint'(fv + rvv) * longint'($signed(c[k*COEF_W +: COEF_W]));
    end
    if (ac) mAcc = mAcc + ACC_W'(p);
    else begin mHold = mAcc; mAcc = ACC_W'(p); end
  endtask

  // One input cycle: check the output due now (R10 latency), then drive.
  task automatic step(input logic signed [DATA_W-1:0] x,
                      input logic [PAIRS*COEF_W-1:0] c,
                      input bit sh, input bit fw, input bit rv,
                      input bit xf, input bit ac);
    @(negedge clk);
    check(tag, holdOut, (stepIdx >= 4) ? expHold[stepIdx-4] : '0);
    sampleIn = x; coefIn = c;
    shiftEn_n = !sh; fwdEn_n = !fw; revEn_n = !rv; xfer_n = !xf; accEn = ac;
    modelStep(x, c, sh, fw, rv, xf, ac);
    expHold[stepIdx] = mHold;
    stepIdx++;
  endtask

  task automatic flush();
    for (int i = 0; i < 5; i++) step('0, '0, 0, 0, 0, 0, 1);
  endtask

  task automatic doReset(input int d);
    @(negedge clk);
    rst = 1'b1;
    sampleIn = '0; coefIn = '0;
    shiftEn_n = 1'b1; fwdEn_n = 1'b1; revEn_n = 1'b1; xfer_n = 1'b1; accEn = 1'b1;
    decimM1 = 4'(d - 1);
    repeat (3) @(negedge clk);
    check("R1 reset value", holdOut, '0);
    rst = 1'b0;
    modelClear(d);
  endtask

  task automatic randPhase(input int d, input int n, input int gap, input string lbl);
    int sinceX;
    bit sh, fw, rv, xf, ac;
    doReset(d);
    tag = lbl;
    sinceX = 0;
    for (int i = 0; i < n; i++) begin
      sh = ($urandom() % 4) != 0;
      fw = ($urandom() % 5) != 0;
      rv = ($urandom() % 5) != 0;
      ac = ($urandom() % 8) != 0;
      if (sh) sinceX++;
      xf = (sh && sinceX >= gap) || (($urandom() % 64) == 0);
      if (xf) sinceX = 0;
      step(DATA_W'($urandom()), PAIRS*COEF_W'({$urandom(), $urandom()}), sh, fw, rv, xf, ac);
    end
    flush();
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL R10 watchdog: run still active, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    modelClear(1);

    // R1: idle cycles after reset keep the output at zero
    doReset(1);
    tag = "R1 idle after reset";
    for (int i = 0; i < 8; i++) step('0, packC(100, -200, 300, -400), 0, 1, 1, 0, (i % 2) == 0);
    flush();

    // R4: reverse disabled, forward only (asymmetric), D = 1
    doReset(1);
    tag = "R4 forward-only";
    for (int i = 0; i < 24; i++)
      step(DATA_W'(i * 37 - 300), packC(5, -7, 11, 13), 1, 1, 0, 0, (i % 3) != 2);
    flush();

    // R5: forward disabled, reverse only after a swap, D = 1
    doReset(1);
    tag = "R5 reverse-only";
    for (int i = 0; i < 12; i++)
      step(DATA_W'(i * 41 - 250), packC(3, 9, -4, 2), 1, 0, 0, i == 9, 0);
    for (int i = 0; i < 16; i++)
      step(DATA_W'(i * 17), packC(3, 9, -4, 2), 1, 0, 1, 0, (i % 4) != 3);
    flush();

    // R3: shifting stops, operands held, D = 2
    doReset(2);
    tag = "R3 shift held";
    for (int i = 0; i < 14; i++)
      step(DATA_W'(i * 29 - 150), packC(1, 2, 3, 4), 1, 1, 1, i == 10, 0);
    for (int i = 0; i < 12; i++)
      step(DATA_W'(511), packC(1, 2, 3, 4), 0, 1, 1, 0, (i % 2) == 0);
    flush();

    // R11: accumulator wraps modulo 2^28
    doReset(1);
    tag = "R11 accumulator wrap";
    for (int i = 0; i < 6; i++) step(DATA_W'(-512), '0, 1, 0, 0, 0, 0);
    for (int i = 0; i < 200; i++)
      step('0, packC(-512, -512, -512, -512), 0, 1, 0, 0, 1);
    step('0, '0, 0, 0, 0, 0, 0);
    flush();
    check("R11 wrapped value", holdOut, -28'sd58720256);

    // R2 R6 R7 R8 R9 R10: random mixes at several decimation factors
    randPhase(1,  600,  4,  "R2 R6 R7 R8 R9 R10 D=1");
    randPhase(3,  800,  12, "R2 R6 R7 R8 R9 R10 D=3");
    randPhase(16, 1500, 100, "R2 R6 R7 R8 R9 R10 D=16 full LIFO");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule